// File: doc/BRIEF.md
# Two-Tone Direct Digital Synthesis Stimulus Generator

This block produces the digital test stimulus for checking an analog signal path on chip. It synthesizes sine tones with phase accumulators that address a computed sine table. In two-tone mode, two independently tuned tones are each scaled to half amplitude and added into one 8-bit word for a DAC. That stimulus suits linearity measurement. A third synthesis channel is tuned to the third-order intermodulation product 2·Fb−Fa and gives a coherent reference for a response analyzer.

A fourth channel provides quadrature references for gain and phase measurement. One accumulator drives both a sine and a cosine lookup. In single-tone mode its cosine also becomes the DAC stimulus. All samples are signed two's complement. A synchronous reset makes every run start from zero phase.

Top module: `tone_pair_synth`

## Requirements
- R1: Each channel has a 16-bit phase accumulator. On every clock edge with enable high, it adds its 16-bit frequency word modulo 65536, so the tone frequency is fclk·F/65536.
- R2: A tone sample is the table value T(k) = round-half-away(127·sin(2π·k/256)), an 8-bit signed two's complement word. The index k is bits 15:8 of the accumulator.
- R3: With single_tone low, dac_out = (T(ka) >>> 1) + (T(kb) >>> 1), using arithmetic shifts. When both tones peak together, this yields 126 and −128 without overflow.
- R4: im_ref is T(ki). The index ki comes from a third accumulator that steps by (2·freq_b − freq_a) mod 65536.
- R5: ref_sin = T(kq) and ref_cos = T((kq+64) mod 256). Both are taken from one accumulator that steps by freq_q. With single_tone high, dac_out equals ref_cos.
- R6: A clock edge with rst_n low clears all accumulators and all outputs to zero.
- R7: While enable is low, every accumulator holds its phase. The outputs keep showing the samples of the held phases.
- R8: A new frequency word is used at the very next clock edge. The accumulated phase is not reset.
- R9: Every output is registered. After an edge, it shows the sample for the phase held just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Advances all accumulators when high |
| single_tone | input | 1 | 0: two-tone sum on dac_out, 1: quadrature cosine on dac_out |
| freq_a | input | 16 | Frequency word of tone A |
| freq_b | input | 16 | Frequency word of tone B |
| freq_q | input | 16 | Frequency word of the quadrature channel |
| dac_out | output | 8 | Signed stimulus word for the DAC |
| im_ref | output | 8 | Signed reference at 2·Fb−Fa |
| ref_sin | output | 8 | Signed sine reference of the quadrature channel |
| ref_cos | output | 8 | Signed cosine reference of the quadrature channel |

## Verification
The hardest condition to produce is both tones reaching a peak in the same cycle, since that is the only way to reach the extremes of the two-tone sum. Drifting tones almost never line up there. The stimulus therefore resets both phases and then drives the two words to a quarter turn each (0x4000). This walks both tones through +127 and −127 together and brings 126 and −128 onto dac_out. The intermodulation word is exercised as well: choosing freq_a larger than twice freq_b makes the internal step wrap below zero.

// File: rtl/tone_pkg.sv
// Shared types for the two-tone stimulus generator.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tone_pkg;
    // What drives the DAC word.
    typedef enum logic {
        STIM_TWO_TONE = 1'b0,
        STIM_QUAD_COS = 1'b1
    } stim_sel_e;
endpackage

// File: rtl/tone_phase_acc.sv
// Phase accumulator: adds a frequency word on every enabled clock and wraps modulo 2^PHASE_W.
// Assumes a synchronous active-low reset that forces zero phase.
module tone_phase_acc #(
    parameter int unsigned PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PHASE_W-1:0] step,
    output logic [PHASE_W-1:0] phase
);
    // Advance the phase by the step, or hold it while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (enable)
            phase <= phase + step;
    end
endmodule

// File: rtl/tone_sine_rom.sv
// Sine lookup computed at elaboration: entry k = round(AMP*sin(2*pi*k/DEPTH)).
// QUARTER=1 advances the index by a quarter turn, which gives a cosine.
// Assumes the combinational read is registered downstream.
module tone_sine_rom #(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SAMP_W  = 8,
    parameter bit          QUARTER = 1'b0
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] sample
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned OFS   = QUARTER ? DEPTH / 4 : 0;
    localparam real         AMP   = real'((1 << (SAMP_W - 1)) - 1);
    localparam real         TWO_PI = 6.283185307179586;

    logic signed [SAMP_W-1:0] tbl [DEPTH];

    // Fill every entry with its rounded sine value.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam real VAL = AMP * $sin(TWO_PI * real'(i) / real'(DEPTH));
        assign tbl[i] = SAMP_W'($rtoi(VAL >= 0.0 ? VAL + 0.5 : VAL - 0.5));
    end

    // Read with the optional quarter-turn offset.
    assign sample = tbl[ADDR_W'(addr + ADDR_W'(OFS))];
endmodule

// File: rtl/tone_pair_synth.sv
// Two-tone stimulus generator: two half-scale tones summed for a DAC, an
// intermodulation reference at 2*Fb-Fa, and quadrature references from a
// shared accumulator. All outputs are registered; the reset is synchronous active-low.
module tone_pair_synth #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned SAMP_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     single_tone,
    input  logic [PHASE_W-1:0]       freq_a,
    input  logic [PHASE_W-1:0]       freq_b,
    input  logic [PHASE_W-1:0]       freq_q,
    output logic signed [SAMP_W-1:0] dac_out,
    output logic signed [SAMP_W-1:0] im_ref,
    output logic signed [SAMP_W-1:0] ref_sin,
    output logic signed [SAMP_W-1:0] ref_cos
);
    import tone_pkg::*;

    localparam int unsigned N_CH = 4;
    localparam int unsigned CH_A = 0, CH_B = 1, CH_I = 2, CH_Q = 3;

    logic [PHASE_W-1:0] step_w  [N_CH];
    logic [PHASE_W-1:0] phase_w [N_CH];
    logic [PHASE_W-1:0] phase_a, phase_im;
    logic [PHASE_W-1:0] im_step;
    logic signed [SAMP_W-1:0] samp_a, samp_b, samp_i, samp_s, samp_c, two_tone;
    stim_sel_e sel;

    // Step of the intermodulation channel, wrapped modulo 2^PHASE_W.
    assign im_step = freq_b + freq_b - freq_a;

    assign step_w[CH_A] = freq_a;
    assign step_w[CH_B] = freq_b;
    assign step_w[CH_I] = im_step;
    assign step_w[CH_Q] = freq_q;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tone_phase_acc #(.PHASE_W(PHASE_W)) acc_i (
            .clk(clk), .rst_n(rst_n), .enable(enable),
            .step(step_w[c]), .phase(phase_w[c])
        );
    end

    assign phase_a  = phase_w[CH_A];
    assign phase_im = phase_w[CH_I];

    tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .QUARTER(1'b0)) rom_a (
        .addr(phase_w[CH_A][PHASE_W-1 -: ADDR_W]), .sample(samp_a));
    tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .QUARTER(1'b0)) rom_b (
        .addr(phase_w[CH_B][PHASE_W-1 -: ADDR_W]), .sample(samp_b));
    tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .QUARTER(1'b0)) rom_i (
        .addr(phase_w[CH_I][PHASE_W-1 -: ADDR_W]), .sample(samp_i));
    tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .QUARTER(1'b0)) rom_s (
        .addr(phase_w[CH_Q][PHASE_W-1 -: ADDR_W]), .sample(samp_s));
    tone_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .QUARTER(1'b1)) rom_c (
        .addr(phase_w[CH_Q][PHASE_W-1 -: ADDR_W]), .sample(samp_c));

    // Half-scale sum keeps the two-tone word inside the signed range.
    assign two_tone = (samp_a >>> 1) + (samp_b >>> 1);
    assign sel      = stim_sel_e'(single_tone);

    // Register every output for a single-cycle, glitch-free latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_out <= '0;
            im_ref  <= '0;
            ref_sin <= '0;
            ref_cos <= '0;
        end else begin
            dac_out <= (sel == STIM_QUAD_COS) ? samp_c : two_tone;
            im_ref  <= samp_i;
            ref_sin <= samp_s;
            ref_cos <= samp_c;
        end
    end
endmodule

// File: rtl/tone_pair_synth_chk.sv
// Checker for tone_pair_synth: accumulator stepping, hold, intermodulation
// step and cosine stimulus selection. Attached to the top through bind.
module tone_pair_synth_chk #(
    parameter int unsigned PHASE_W = 16,
    parameter int unsigned SAMP_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     enable,
    input logic                     single_tone,
    input logic [PHASE_W-1:0]       freq_a,
    input logic [PHASE_W-1:0]       freq_b,
    input logic [PHASE_W-1:0]       phase_a,
    input logic [PHASE_W-1:0]       phase_im,
    input logic signed [SAMP_W-1:0] dac_out,
    input logic signed [SAMP_W-1:0] ref_cos
);
    // R1, R8: an enabled edge adds the word present at that edge.
    a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> phase_a == PHASE_W'($past(phase_a) + $past(freq_a)));

    // R7: a disabled edge keeps the phase.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> phase_a == $past(phase_a));

    // R4: the third channel steps by twice B minus A.
    a_r4_im_step: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> phase_im == PHASE_W'($past(phase_im) + $past(freq_b) + $past(freq_b) - $past(freq_a)));

    // R5: single-tone mode puts the cosine on the DAC word.
    a_r5_cos_stim: assert property (@(posedge clk) disable iff (!rst_n)
        single_tone |=> dac_out == ref_cos);
endmodule

bind tone_pair_synth tone_pair_synth_chk #(.PHASE_W(PHASE_W), .SAMP_W(SAMP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .single_tone(single_tone),
    .freq_a(freq_a), .freq_b(freq_b), .phase_a(phase_a), .phase_im(phase_im),
    .dac_out(dac_out), .ref_cos(ref_cos)
);

// File: tb/tone_pair_synth_tb.sv
// Bench: a behavioural per-cycle model compared with every output on each clock.
module tone_pair_synth_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic single_tone = 1'b0;
    logic [15:0] freq_a = '0, freq_b = '0, freq_q = '0;
    logic signed [7:0] dac_out, im_ref, ref_sin, ref_cos;

    int n_chk = 0, n_fail = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    string tag = "R6";
    int dac_min = 1000, dac_max = -1000;

    int m_pa = 0, m_pb = 0, m_pi = 0, m_pq = 0;
    int m_dac = 0, m_im = 0, m_sin = 0, m_cos = 0;

    always #5 clk = ~clk;

    tone_pair_synth dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .single_tone(single_tone),
        .freq_a(freq_a), .freq_b(freq_b), .freq_q(freq_q),
        .dac_out(dac_out), .im_ref(im_ref), .ref_sin(ref_sin), .ref_cos(ref_cos)
    );

    // R2 table from its definition.
    function automatic int tsin(int k);
        real v;
        v = 127.0 * $sin(6.283185307179586 * real'(k % 256) / 256.0);
        return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
    endfunction

    // Reference model, one step per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pa = 0; m_pb = 0; m_pi = 0; m_pq = 0;
            m_dac = 0; m_im = 0; m_sin = 0; m_cos = 0;
            checking = 1'b1;
        end else begin
            m_sin = tsin(m_pq / 256);
            m_cos = tsin(m_pq / 256 + 64);
            m_im  = tsin(m_pi / 256);
            m_dac = single_tone ? m_cos : ((tsin(m_pa / 256) >>> 1) + (tsin(m_pb / 256) >>> 1));
            if (enable) begin
                m_pa = (m_pa + int'(freq_a)) % 65536;
                m_pb = (m_pb + int'(freq_b)) % 65536;
                m_pi = (m_pi + 2 * int'(freq_b) - int'(freq_a) + 131072) % 65536;
                m_pq = (m_pq + int'(freq_q)) % 65536;
            end
        end
    end

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            check({tag, " R3/R5/R9 dac_out"}, int'(dac_out), m_dac);
            check({tag, " R4 im_ref"},       int'(im_ref),  m_im);
            check({tag, " R5 ref_sin"},      int'(ref_sin), m_sin);
            check({tag, " R5 ref_cos"},      int'(ref_cos), m_cos);
            if (int'(dac_out) < dac_min) dac_min = int'(dac_out);
            if (int'(dac_out) > dac_max) dac_max = int'(dac_out);
        end
    end

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        run(3);
        // R6: state right after reset.
        check("R6 reset dac_out", int'(dac_out), 0);
        check("R6 reset im_ref",  int'(im_ref), 0);
        rst_n = 1'b1; enable = 1'b1;
        tag = "R1";
        freq_a = 16'h0400; freq_b = 16'h0500; freq_q = 16'h0300;
        run(300);
        tag = "R8";
        freq_a = 16'h0A31; freq_b = 16'h0C07;
        run(150);
        tag = "R1 wrap";
        freq_a = 16'hFFF0; freq_b = 16'h8001; freq_q = 16'hF123;
        run(200);
        tag = "R4 neg step";
        freq_a = 16'h3000; freq_b = 16'h0200;
        run(200);
        tag = "R7";
        enable = 1'b0;
        run(20);
        enable = 1'b1;
        tag = "R5";
        single_tone = 1'b1; freq_q = 16'h0700;
        run(200);
        single_tone = 1'b0;
        // R3 boundary: both tones peak together after a fresh reset.
        tag = "R6 rerun";
        rst_n = 1'b0;
        run(2);
        check("R6 mid-run reset ref_sin", int'(ref_sin), 0);
        rst_n = 1'b1;
        tag = "R3 peak";
        dac_min = 1000; dac_max = -1000;
        freq_a = 16'h4000; freq_b = 16'h4000;
        run(12);
        check("R3 peak max", dac_max, 126);
        check("R3 peak min", dac_min, -128);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule